// File: doc/BRIEF.md
# Erased Page Judge for Reed-Solomon Reads

This block sits beside a flash read path and decides, once a whole page has streamed past, whether a read that the Reed-Solomon decoder flagged as failing was in fact a blank (erased) page. When the decoder meets a blank codeword it raises the codeword's operation-error status and plants the byte 0x54 at one of two fixed positions inside that codeword: offset 3 or offset 175. A plain all-ones test would therefore reject every blank page. This block looks for that planted byte instead, and treats the two marker positions as if they held 0xFF.

Page bytes arrive one codeword at a time. Each byte comes with a valid strobe, a start marker on the first byte of a codeword and a last marker on its final byte. The error status of each codeword is sampled with its start byte. Configuration inputs select the ECC mode, enable ECC, and give the codeword count per page (1 to 16) and the data bytes per codeword (176 to 512). Pages of 512 B, 2 kB, 4 kB and 8 kB are covered by 1, 4, 8 or 16 codewords of 512 bytes. After the last byte of the page a one-cycle verdict strobe appears, together with a held empty flag and a held flag that tells the error logic to drop the read error. The outputs are passive: when the page is not empty, the error logic keeps the decoder's original status.

Top module: `erased_page_judge`

## Requirements
- R1: A synchronous active-high `rst` clears `verdict_valid`, `verdict_empty` and `suppress_err` to 0 on the next clock edge, including while a previous verdict is being held.
- R2: `verdict_valid` is high for exactly one cycle. That cycle is the one right after the clock edge that accepts the byte carrying `in_last` of codeword number `cfg_cw_per_page` of the page.
- R3: `verdict_empty` can only be 1 when `cfg_rs_mode`=1 (Reed-Solomon; 0 selects BCH) and `cfg_ecc_en`=1 at the page's final byte. With any other setting the verdict is not empty.
- R4: A codeword whose `in_op_err`, sampled with its start byte, is 0 makes the page not empty.
- R5: A codeword passes the marker test only when exactly one of its bytes at offsets 3 and 175 is 0x54 and the other is 0xFF. Both 0x54, both 0xFF, or any other value fails the codeword.
- R6: Every byte of every codeword other than those at offsets 3 and 175 must be 0xFF, or the page is not empty.
- R7: A failure is sticky. Later good codewords of the same page are still consumed, but the verdict stays not empty.
- R8: `verdict_empty` and `suppress_err` hold their value after the verdict until the next page's first accepted start byte. They read 0 from the cycle after that byte.
- R9: A start byte that arrives while a codeword is still open aborts that codeword as failed. The page still ends on the `cfg_cw_per_page`-th `in_last`.
- R10: A codeword passes only if `in_last` falls on byte offset `cfg_cw_bytes`-1. A shorter or longer codeword fails.
- R11: `suppress_err` equals `verdict_empty`.
- R12: Inputs on cycles with `in_valid`=0 are ignored, including any start or last markers present on those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_rs_mode | input | 1 | 1 = Reed-Solomon ECC, 0 = BCH |
| cfg_ecc_en | input | 1 | ECC enabled |
| cfg_cw_per_page | input | 5 | Codewords per page, 1..16 |
| cfg_cw_bytes | input | 10 | Data bytes per codeword, 176..512 |
| in_valid | input | 1 | Byte strobe |
| in_cw_start | input | 1 | First byte of a codeword |
| in_last | input | 1 | Final byte of a codeword |
| in_byte | input | 8 | Data byte |
| in_op_err | input | 1 | Operation-error status of the codeword, sampled with its start byte |
| verdict_valid | output | 1 | One-cycle strobe at page end |
| verdict_empty | output | 1 | Page judged erased, held until the next page |
| suppress_err | output | 1 | Tells the error logic to drop the read error, held like the verdict |

## Verification
The bench builds the block with its default parameters: 512 bytes and 16 codewords at most, markers at offsets 3 and 175. It varies the runtime configuration so that 1-, 4- and 16-codeword pages are all run. A 176-byte codeword puts marker 175 on the very byte that carries the last marker, which exercises the path where the marker is checked in the same cycle the codeword closes. A 16×512 page covers the largest 8 kB case and the full width of the codeword counter. The remaining pages vary the position of the 0x54 marker, the error status, mode gating, codeword length, early restarts and idle gaps with junk on the bus.

// File: rtl/epd_pkg.sv
package epd_pkg;
    localparam logic [7:0] BYTE_BLANK  = 8'hFF;
    localparam logic [7:0] BYTE_MARKER = 8'h54;

    // exactly one of the two positions carries the marker, the other is blank
    function automatic logic marker_pair_ok(input logic [7:0] a, input logic [7:0] b);
        return ((a == BYTE_MARKER) && (b == BYTE_BLANK)) ||
               ((a == BYTE_BLANK)  && (b == BYTE_MARKER));
    endfunction
endpackage

// File: rtl/epd_cw_scan.sv
module epd_cw_scan
    import epd_pkg::*;
#(
    parameter int CW_BYTES_MAX = 512,
    parameter int OFS_A        = 3,
    parameter int OFS_B        = 175,
    localparam int IW          = $clog2(CW_BYTES_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] cfg_cw_bytes,
    input  logic          in_valid,
    input  logic          in_cw_start,
    input  logic          in_last,
    input  logic [7:0]    in_byte,
    input  logic          in_op_err,
    output logic          cw_begin,
    output logic          cw_done,
    output logic          cw_pass,
    output logic          cw_abort
);
    typedef struct packed {
        logic          active;
        logic [IW-1:0] idx;
        logic          op_err;
        logic          clean;
        logic [7:0]    mark_a;
        logic [7:0]    mark_b;
    } scan_t;

    scan_t st_q, st_d;

    logic          take;
    logic [IW-1:0] idx_now;
    logic          is_a, is_b, in_range, len_ok;
    logic          op_now, clean_now;
    logic [7:0]    cur_a, cur_b;

    always_comb begin
        st_d     = st_q;
        cw_done  = 1'b0;
        cw_pass  = 1'b0;
        cw_abort = 1'b0;

        take      = in_valid && (in_cw_start || st_q.active);
        cw_begin  = in_valid && in_cw_start;
        idx_now   = in_cw_start ? '0 : st_q.idx;
        is_a      = (idx_now == IW'(OFS_A));
        is_b      = (idx_now == IW'(OFS_B));
        in_range  = (idx_now < cfg_cw_bytes);
        len_ok    = (({1'b0, idx_now} + (IW+1)'(1)) == {1'b0, cfg_cw_bytes});
        op_now    = in_cw_start ? in_op_err : st_q.op_err;
        cur_a     = is_a ? in_byte : (in_cw_start ? 8'h00 : st_q.mark_a);
        cur_b     = is_b ? in_byte : (in_cw_start ? 8'h00 : st_q.mark_b);
        clean_now = (in_cw_start ? 1'b1 : st_q.clean) && in_range &&
                    (is_a || is_b || (in_byte == BYTE_BLANK));

        if (take) begin
            cw_abort = in_cw_start && st_q.active;
            if (in_last) begin
                cw_done     = 1'b1;
                cw_pass     = op_now && clean_now && len_ok && marker_pair_ok(cur_a, cur_b);
                st_d.active = 1'b0;
                st_d.idx    = '0;
            end else begin
                st_d.active = 1'b1;
                st_d.idx    = (idx_now == '1) ? idx_now : idx_now + IW'(1);
                st_d.op_err = op_now;
                st_d.clean  = clean_now;
                st_d.mark_a = cur_a;
                st_d.mark_b = cur_b;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/epd_page_tally.sv
module epd_page_tally #(
    parameter int MAX_CW  = 16,
    localparam int CW_W   = $clog2(MAX_CW + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW_W-1:0] cfg_cw_per_page,
    input  logic            mode_ok,
    input  logic            cw_begin,
    input  logic            cw_done,
    input  logic            cw_pass,
    input  logic            cw_abort,
    output logic            verdict_valid,
    output logic            verdict_empty
);
    typedef struct packed {
        logic            in_page;
        logic [CW_W-1:0] cnt;
        logic            fail;
        logic            vld;
        logic            empty;
    } tally_t;

    tally_t st_q, st_d;

    logic            page_start;
    logic [CW_W-1:0] cnt_now;
    logic            fail_now;
    logic            last_cw;

    always_comb begin
        st_d       = st_q;
        st_d.vld   = 1'b0;
        page_start = cw_begin && !st_q.in_page;
        cnt_now    = page_start ? '0 : st_q.cnt;
        fail_now   = (page_start ? 1'b0 : st_q.fail) || cw_abort;
        last_cw    = (({1'b0, cnt_now} + (CW_W+1)'(1)) >= {1'b0, cfg_cw_per_page});

        if (page_start) begin
            st_d.in_page = 1'b1;
            st_d.empty   = 1'b0;
        end
        st_d.cnt  = cnt_now;
        st_d.fail = fail_now;

        if (cw_done && (page_start || st_q.in_page)) begin
            if (last_cw) begin
                st_d.vld     = 1'b1;
                st_d.empty   = mode_ok && !fail_now && cw_pass;
                st_d.in_page = 1'b0;
                st_d.cnt     = '0;
                st_d.fail    = 1'b0;
            end else begin
                st_d.cnt  = cnt_now + CW_W'(1);
                st_d.fail = fail_now || !cw_pass;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign verdict_valid = st_q.vld;
    assign verdict_empty = st_q.empty;
endmodule

// File: rtl/erased_page_judge.sv
module erased_page_judge #(
    parameter int CW_BYTES_MAX = 512,
    parameter int MAX_CW       = 16,
    parameter int OFS_A        = 3,
    parameter int OFS_B        = 175,
    localparam int IW          = $clog2(CW_BYTES_MAX + 1),
    localparam int CW_W        = $clog2(MAX_CW + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_rs_mode,
    input  logic            cfg_ecc_en,
    input  logic [CW_W-1:0] cfg_cw_per_page,
    input  logic [IW-1:0]   cfg_cw_bytes,
    input  logic            in_valid,
    input  logic            in_cw_start,
    input  logic            in_last,
    input  logic [7:0]      in_byte,
    input  logic            in_op_err,
    output logic            verdict_valid,
    output logic            verdict_empty,
    output logic            suppress_err
);
    logic cw_begin, cw_done, cw_pass, cw_abort;
    logic mode_ok;

    assign mode_ok = cfg_rs_mode && cfg_ecc_en;

    epd_cw_scan #(
        .CW_BYTES_MAX(CW_BYTES_MAX),
        .OFS_A       (OFS_A),
        .OFS_B       (OFS_B)
    ) u_scan (
        .clk         (clk),
        .rst         (rst),
        .cfg_cw_bytes(cfg_cw_bytes),
        .in_valid    (in_valid),
        .in_cw_start (in_cw_start),
        .in_last     (in_last),
        .in_byte     (in_byte),
        .in_op_err   (in_op_err),
        .cw_begin    (cw_begin),
        .cw_done     (cw_done),
        .cw_pass     (cw_pass),
        .cw_abort    (cw_abort)
    );

    epd_page_tally #(
        .MAX_CW(MAX_CW)
    ) u_tally (
        .clk            (clk),
        .rst            (rst),
        .cfg_cw_per_page(cfg_cw_per_page),
        .mode_ok        (mode_ok),
        .cw_begin       (cw_begin),
        .cw_done        (cw_done),
        .cw_pass        (cw_pass),
        .cw_abort       (cw_abort),
        .verdict_valid  (verdict_valid),
        .verdict_empty  (verdict_empty)
    );

    assign suppress_err = verdict_empty;
endmodule

// File: rtl/epd_checker.sv
module epd_checker (
    input logic clk,
    input logic rst,
    input logic cfg_rs_mode,
    input logic cfg_ecc_en,
    input logic in_valid,
    input logic in_cw_start,
    input logic verdict_valid,
    input logic verdict_empty,
    input logic suppress_err
);
    // R1: the cycle after reset leaves everything cleared
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!verdict_valid && !verdict_empty && !suppress_err));

    // R2: the verdict strobe lasts a single cycle
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |=> !verdict_valid);

    // R3: outside Reed-Solomon with ECC on, never empty
    assert_mode_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && !$past(cfg_rs_mode && cfg_ecc_en)) |-> !verdict_empty);

    // R8: the held verdict only moves on a new verdict or after a start byte
    assert_verdict_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!(in_valid && in_cw_start) ##1 !verdict_valid) |-> $stable(verdict_empty));
endmodule

bind erased_page_judge epd_checker u_chk (.*);

// File: tb/test_erased_page_judge.sv
`timescale 1ns/1ps
module test_erased_page_judge;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_rs_mode = 1'b1;
    logic       cfg_ecc_en = 1'b1;
    logic [4:0] cfg_cw_per_page = 5'd1;
    logic [9:0] cfg_cw_bytes = 10'd512;
    logic       in_valid = 1'b0;
    logic       in_cw_start = 1'b0;
    logic       in_last = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_op_err = 1'b0;
    logic       verdict_valid, verdict_empty, suppress_err;

    always #2 clk = ~clk;

    erased_page_judge i_erased_page_judge (.*);

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic prev_vld = 1'b0;

    logic [7:0] pg [0:8191];
    logic       opv [0:15];

    bit    exp_q[$];
    int    cyc_q[$];
    string tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (verdict_valid) begin
                check(!prev_vld, "R2 strobe wider than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected verdict", 1, 0);
                end else begin
                    automatic bit    e = exp_q.pop_front();
                    automatic int    c = cyc_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(verdict_empty == e, {t, " verdict_empty"}, verdict_empty, e);
                    check(suppress_err == e, {t, " R11 suppress_err"}, suppress_err, e);
                    check(cyc == c, {t, " R2 verdict cycle"}, cyc, c);
                end
            end
            prev_vld = verdict_valid;
        end else begin
            prev_vld = 1'b0;
        end
    end

    task automatic drive(input logic [7:0] b, input logic s, input logic l, input logic op);
        @(posedge clk); #1;
        in_valid = 1'b1; in_byte = b; in_cw_start = s; in_last = l; in_op_err = op;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 1'b0; in_cw_start = 1'b0; in_last = 1'b0; in_byte = 8'h00;
    endtask

    // R12: junk with markers on an idle cycle
    task automatic gap();
        @(posedge clk); #1;
        in_valid = 1'b0; in_cw_start = 1'b1; in_last = 1'b1; in_byte = 8'h00; in_op_err = 1'b0;
    endtask

    // which: 0 marker at offset 3, 1 at offset 175, 2 alternating per codeword
    task automatic fill(input int ncw, input int len, input int which);
        for (int i = 0; i < ncw * len; i++) pg[i] = 8'hFF;
        for (int i = 0; i < ncw; i++) begin
            automatic bit use_b = (which == 1) || ((which == 2) && (i % 2 == 1));
            pg[i * len + (use_b ? 175 : 3)] = 8'h54;
            opv[i] = 1'b1;
        end
    endtask

    task automatic send_page(input int ncw, input int len, input bit gaps, input int abort_cw,
                             input int short_len, input bit exp, input string tag);
        cfg_cw_per_page = 5'(ncw);
        cfg_cw_bytes    = 10'(len);
        for (int i = 0; i < ncw; i++) begin
            automatic int base = i * len;
            automatic int n = (i == 0 && short_len > 0) ? short_len : len;
            if (i == abort_cw)
                for (int j = 0; j < 50; j++) drive(pg[base + j], j == 0, 1'b0, opv[i]);
            for (int j = 0; j < n; j++) begin
                drive(pg[base + j], j == 0, j == n - 1, opv[i]);
                if (gaps && (j % 7 == 3) && (j != n - 1)) gap();
            end
        end
        exp_q.push_back(exp);
        cyc_q.push_back(cyc + 1);
        tag_q.push_back(tag);
        idle();
        idle();
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!verdict_valid, "R1 reset verdict_valid", verdict_valid, 0);
        check(!verdict_empty, "R1 reset verdict_empty", verdict_empty, 0);
        check(!suppress_err, "R1 reset suppress_err", suppress_err, 0);
        @(posedge clk); #1 rst = 1'b0;

        fill(4, 512, 2);
        send_page(4, 512, 0, -1, 0, 1, "R5 R6 2kB alternating markers");
        fill(1, 176, 1);
        send_page(1, 176, 0, -1, 0, 1, "R5 marker on final byte");
        fill(16, 512, 0);
        send_page(16, 512, 0, -1, 0, 1, "R2 8kB page");

        fill(4, 512, 2); pg[512 + 3] = 8'h54; pg[512 + 175] = 8'h54;
        send_page(4, 512, 0, -1, 0, 0, "R5 both markers 0x54");
        fill(4, 512, 0); pg[3] = 8'hFF;
        send_page(4, 512, 0, -1, 0, 0, "R5 both markers 0xFF");
        fill(4, 512, 2); pg[3] = 8'h55;
        send_page(4, 512, 0, -1, 0, 0, "R5 marker value wrong");
        fill(4, 512, 2); pg[2 * 512 + 400] = 8'hFE;
        send_page(4, 512, 0, -1, 0, 0, "R6 stray data byte");

        fill(4, 512, 2); opv[3] = 1'b0;
        send_page(4, 512, 0, -1, 0, 0, "R4 status clear");

        fill(2, 512, 2); cfg_rs_mode = 1'b0;
        send_page(2, 512, 0, -1, 0, 0, "R3 BCH mode");
        cfg_rs_mode = 1'b1; cfg_ecc_en = 1'b0;
        send_page(2, 512, 0, -1, 0, 0, "R3 ECC off");
        cfg_ecc_en = 1'b1;

        fill(4, 512, 2); pg[10] = 8'h00;
        send_page(4, 512, 0, -1, 0, 0, "R7 first codeword bad");

        fill(4, 512, 2);
        send_page(4, 512, 0, 2, 0, 0, "R9 early start");
        send_page(4, 512, 0, -1, 300, 0, "R10 short codeword");

        send_page(4, 512, 1, -1, 0, 1, "R12 idle junk");

        // R8: held, then cleared by the next start byte
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(verdict_empty == 1'b1, "R8 verdict held", verdict_empty, 1);
        check(suppress_err == 1'b1, "R8 suppress held", suppress_err, 1);
        drive(8'hFF, 1'b1, 1'b0, 1'b1);
        idle();
        @(negedge clk);
        check(verdict_empty == 1'b0, "R8 cleared by next start", verdict_empty, 0);
        check(suppress_err == 1'b0, "R8 suppress cleared", suppress_err, 0);

        // R1: reset during a held verdict
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        fill(1, 512, 0);
        send_page(1, 512, 0, -1, 0, 1, "R1 page after reset");
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        check(!verdict_empty && !suppress_err, "R1 reset clears held verdict", verdict_empty, 0);
        @(posedge clk); #1 rst = 1'b0;

        repeat (4) @(posedge clk);
        check(exp_q.size() == 0, "R2 missing verdicts", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule